// File: doc/BRIEF.md
# CPU Memory Contention Delay Unit

This unit decides how long a CPU access must be stretched when the CPU shares its memory with a raster video fetcher. Every 2 MHz CPU cycle it looks at the raster position and the display mode. From these it produces the number of 2 MHz cycles the access would take if it were issued in that cycle. The raster position is the horizontal position in 16 MHz pixel units, the line count and the character row. The display mode is 40 or 80 columns, and text or graphics.

Slow I/O accesses run on a 1 MHz bus, so their length depends on the phase of that bus. In 80-column modes the video fetcher owns memory for the whole active part of a line, so a RAM access made there waits until the active part ends. In every other case a RAM access has the same delay as an I/O access.

When a request is accepted, the delay computed in that cycle is loaded into a down-counter. The registered ready output is held low until the counter reaches 1. Requests that arrive during a stall are ignored.

Top module: `contention_delay_unit`

## Requirements
- R1: When `req_is_io` is 1 (I/O access), `delay_out` equals 2 plus bit 3 of `hpos`, in the same cycle.
- R2: When `req_is_io` is 0 (RAM), `wide_mode` is 1 (80 columns) and the raster is not blanked, `delay_out` equals 2 + ((640 − `hpos`) >> 3).
- R3: When `req_is_io` is 0 and either `wide_mode` is 0 (40 columns) or the raster is blanked, `delay_out` equals 2 plus bit 3 of `hpos`.
- R4: The raster is blanked when `hpos` ≥ 640, or `crow` ≥ 8, or `vline` ≥ 250 with `text_mode` = 1 (text), or `vline` ≥ 256 with `text_mode` = 0 (graphics).
- R5: `delay_out` always lies between 2 and 82 inclusive, for `hpos` a multiple of 8.
- R6: A request seen while `ready` is 1 drops `ready` at the next edge. `ready` then stays 0 for exactly D−1 cycles in total, where D is the `delay_out` of the request cycle, and then returns to 1.
- R7: A request made while `ready` is 0 neither restarts nor lengthens the stall in progress.
- R8: A synchronous active-high `rst` sets `ready` to 1 at the next edge and aborts any stall in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2 MHz CPU cycle clock |
| rst | input | 1 | Synchronous reset, active high |
| hpos | input | 10 | Horizontal position in pixel clocks, a multiple of 8 |
| vline | input | 9 | Line count within the field |
| crow | input | 4 | Character row within a text or graphics row |
| wide_mode | input | 1 | 1 = 80-column mode, 0 = 40-column mode |
| text_mode | input | 1 | 1 = text mode, 0 = graphics mode |
| req_valid | input | 1 | CPU access requested this cycle |
| req_is_io | input | 1 | 1 = slow I/O access, 0 = RAM access |
| delay_out | output | 7 | Cycles an access issued now would take |
| ready | output | 1 | Registered; 0 while an accepted access is stalled |

## Verification
The bound checker looks at every cycle. It checks that the delay stays within its legal range, that a horizontally blanked position never yields a long RAM wait, that an accepted request loads exactly the delay shown at the ports, and that a stall counts down one step per cycle and is never reloaded by a request that arrives late. The exact delay formulas and the vertical and character-row blanking thresholds only show up against the bench's reference functions. The bench compares the delay at each boundary line and row, and the full length of each stall, against those functions. Recovery from a reset asserted in the middle of a stall is also shown only by the bench.

// File: rtl/cdu_pkg.sv
package cdu_pkg;
   typedef enum logic {
      ACC_RAM = 1'b0,
      ACC_IO  = 1'b1
   } acc_kind_e;
endpackage

// File: rtl/cdu_blank_detect.sv
module cdu_blank_detect #(
   parameter int H_W       = 10,
   parameter int V_W       = 9,
   parameter int ROW_W     = 4,
   parameter int ACTIVE_W  = 640,
   parameter int TXT_LINES = 250,
   parameter int GPH_LINES = 256,
   parameter int ROW_LIMIT = 8
) (
   input  logic [H_W-1:0]   hpos,
   input  logic [V_W-1:0]   vline,
   input  logic [ROW_W-1:0] crow,
   input  logic             text_mode,
   output logic             blank
);
   localparam int ROW_SPAN = 1 << ROW_W;

   logic h_blank, v_blank, row_blank;

   assign h_blank = ({1'b0, hpos} >= (H_W+1)'(ACTIVE_W));
   assign v_blank = text_mode ? ({1'b0, vline} >= (V_W+1)'(TXT_LINES))
                              : ({1'b0, vline} >= (V_W+1)'(GPH_LINES));

   generate
      if (ROW_SPAN <= ROW_LIMIT) begin : g_row_never
         assign row_blank = 1'b0;
      end else begin : g_row_cmp
         assign row_blank = (crow >= ROW_W'(ROW_LIMIT));
      end
   endgenerate

   assign blank = h_blank | v_blank | row_blank;
endmodule

// File: rtl/cdu_delay_calc.sv
module cdu_delay_calc #(
   parameter int H_W          = 10,
   parameter int D_W          = 7,
   parameter int ACTIVE_W     = 640,
   parameter int IO_BASE      = 2,
   parameter int PHASE_BIT    = 3,
   parameter int FETCH_SHIFT  = 3
) (
   input  logic           [H_W-1:0] hpos,
   input  logic                     wide_mode,
   input  logic                     blank,
   input  cdu_pkg::acc_kind_e       kind,
   output logic           [D_W-1:0] delay
);
   import cdu_pkg::*;

   logic [H_W:0]   remain;
   logic [D_W-1:0] io_wait, ram_wait;

   assign io_wait  = D_W'(IO_BASE) + D_W'(hpos[PHASE_BIT]);
   assign remain   = (H_W+1)'(ACTIVE_W) - {1'b0, hpos};
   assign ram_wait = D_W'(IO_BASE) + D_W'(remain >> FETCH_SHIFT);

   always_comb begin
      if (kind == ACC_RAM && wide_mode && !blank) delay = ram_wait;
      else                                        delay = io_wait;
   end
endmodule

// File: rtl/cdu_stall_timer.sv
module cdu_stall_timer #(
   parameter int D_W = 7
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           req_valid,
   input  logic [D_W-1:0] delay,
   output logic           ready,
   output logic [D_W-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (rst) begin
         cnt   <= D_W'(1);
         ready <= 1'b1;
      end else if (ready) begin
         if (req_valid) begin
            cnt   <= delay;
            ready <= (delay <= D_W'(1));
         end
      end else begin
         cnt   <= cnt - D_W'(1);
         ready <= (cnt == D_W'(2));
      end
   end
endmodule

// File: rtl/contention_delay_unit.sv
module contention_delay_unit #(
   parameter int H_W         = 10,
   parameter int V_W         = 9,
   parameter int ROW_W       = 4,
   parameter int ACTIVE_W    = 640,
   parameter int TXT_LINES   = 250,
   parameter int GPH_LINES   = 256,
   parameter int ROW_LIMIT   = 8,
   parameter int IO_BASE     = 2,
   parameter int PHASE_BIT   = 3,
   parameter int FETCH_SHIFT = 3,
   parameter int D_MAX       = IO_BASE + (ACTIVE_W >> FETCH_SHIFT),
   parameter int D_W         = $clog2(D_MAX + 1)
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [H_W-1:0] hpos,
   input  logic [V_W-1:0] vline,
   input  logic [ROW_W-1:0] crow,
   input  logic           wide_mode,
   input  logic           text_mode,
   input  logic           req_valid,
   input  logic           req_is_io,
   output logic [D_W-1:0] delay_out,
   output logic           ready
);
   import cdu_pkg::*;

   generate
      if (ACTIVE_W % (1 << FETCH_SHIFT) != 0) begin : g_bad_active
         $error("ACTIVE_W must be a multiple of the fetch step");
      end
      if (PHASE_BIT >= H_W || ACTIVE_W >= (1 << H_W)) begin : g_bad_hw
         $error("H_W too narrow for the horizontal timing");
      end
      if (IO_BASE < 2) begin : g_bad_base
         $error("IO_BASE must be at least 2");
      end
   endgenerate

   logic           blank;
   logic [D_W-1:0] stall_cnt;
   acc_kind_e      kind;

   assign kind = req_is_io ? ACC_IO : ACC_RAM;

   cdu_blank_detect #(
      .H_W(H_W), .V_W(V_W), .ROW_W(ROW_W), .ACTIVE_W(ACTIVE_W),
      .TXT_LINES(TXT_LINES), .GPH_LINES(GPH_LINES), .ROW_LIMIT(ROW_LIMIT)
   ) u_blank (
      .hpos(hpos), .vline(vline), .crow(crow), .text_mode(text_mode),
      .blank(blank)
   );

   cdu_delay_calc #(
      .H_W(H_W), .D_W(D_W), .ACTIVE_W(ACTIVE_W), .IO_BASE(IO_BASE),
      .PHASE_BIT(PHASE_BIT), .FETCH_SHIFT(FETCH_SHIFT)
   ) u_calc (
      .hpos(hpos), .wide_mode(wide_mode), .blank(blank), .kind(kind),
      .delay(delay_out)
   );

   cdu_stall_timer #(.D_W(D_W)) u_timer (
      .clk(clk), .rst(rst), .req_valid(req_valid), .delay(delay_out),
      .ready(ready), .cnt(stall_cnt)
   );
endmodule

// File: rtl/cdu_checker.sv
module cdu_checker #(
   parameter int H_W      = 10,
   parameter int D_W      = 7,
   parameter int ACTIVE_W = 640,
   parameter int IO_BASE  = 2,
   parameter int D_MAX    = 82
) (
   input logic           clk,
   input logic           rst,
   input logic           ready,
   input logic           req_valid,
   input logic [H_W-1:0] hpos,
   input logic [D_W-1:0] delay_out,
   input logic [D_W-1:0] stall_cnt
);
   assert_reset_ready_R8: assert property (@(posedge clk)
      rst |=> ready);

   assert_delay_range_R5: assert property (@(posedge clk) disable iff (rst)
      (delay_out >= D_W'(IO_BASE)) && (delay_out <= D_W'(D_MAX)));

   assert_hblank_short_R4: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, hpos} >= (H_W+1)'(ACTIVE_W)) |-> (delay_out <= D_W'(IO_BASE + 1)));

   assert_load_delay_R6: assert property (@(posedge clk) disable iff (rst)
      (ready && req_valid) |=> (!ready && stall_cnt == $past(delay_out)));

   assert_stall_floor_R6: assert property (@(posedge clk) disable iff (rst)
      !ready |-> (stall_cnt >= D_W'(2)));

   assert_no_reload_R7: assert property (@(posedge clk) disable iff (rst)
      !ready |=> (stall_cnt == $past(stall_cnt) - D_W'(1)));
endmodule

bind contention_delay_unit cdu_checker #(
   .H_W(H_W), .D_W(D_W), .ACTIVE_W(ACTIVE_W), .IO_BASE(IO_BASE), .D_MAX(D_MAX)
) u_chk (
   .clk(clk), .rst(rst), .ready(ready), .req_valid(req_valid),
   .hpos(hpos), .delay_out(delay_out), .stall_cnt(stall_cnt)
);

// File: tb/tb_contention_delay_unit.sv
`timescale 1ns/1ps
module tb_contention_delay_unit;
   logic       clk = 1'b0;
   logic       rst;
   logic [9:0] hpos;
   logic [8:0] vline;
   logic [3:0] crow;
   logic       wide_mode, text_mode, req_valid, req_is_io;
   logic [6:0] delay_out;
   logic       ready;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   int exp_cnt   = 1;
   bit exp_ready = 1;

   always #5 clk = ~clk;

   contention_delay_unit dut (
      .clk(clk), .rst(rst), .hpos(hpos), .vline(vline), .crow(crow),
      .wide_mode(wide_mode), .text_mode(text_mode), .req_valid(req_valid),
      .req_is_io(req_is_io), .delay_out(delay_out), .ready(ready)
   );

   function automatic bit ref_blank(int h, int v, int r, bit t);
      return (h >= 640) || (r >= 8) || (t ? (v >= 250) : (v >= 256));
   endfunction

   function automatic int ref_delay(int h, int v, int r, bit w, bit t, bit io);
      int ph;
      ph = (h >> 3) & 1;
      if (!io && w && !ref_blank(h, v, r, t)) return 2 + ((640 - h) >> 3);
      return 2 + ph;
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(bit r_i, int h, int v, int r, bit w, bit t, bit rq, bit io,
                       string dtag, string rtag);
      int d;
      @(negedge clk);
      rst = r_i; hpos = 10'(h); vline = 9'(v); crow = 4'(r);
      wide_mode = w; text_mode = t; req_valid = rq; req_is_io = io;
      #1;
      d = ref_delay(h, v, r, w, t, io);
      check(int'(delay_out) == d, dtag, int'(delay_out), d);
      check(ready == exp_ready, rtag, int'(ready), int'(exp_ready));
      @(posedge clk);
      if (r_i) begin
         exp_cnt = 1; exp_ready = 1;
      end else if (exp_ready) begin
         if (rq) begin exp_cnt = d; exp_ready = 0; end
      end else begin
         exp_ready = (exp_cnt == 2);
         exp_cnt   = exp_cnt - 1;
      end
   endtask

   function automatic string cat_tag(int h, int v, int r, bit w, bit t, bit io);
      if (io) return "R1";
      if (w && !ref_blank(h, v, r, t)) return "R2";
      return "R3";
   endfunction

   initial begin
      #1_500_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      bit r0;
      r0 = $urandom(32'd1234) != 0;
      rst = 1; hpos = 0; vline = 0; crow = 0; wide_mode = 0; text_mode = 0;
      req_valid = 0; req_is_io = 0;
      step(1, 0, 0, 0, 0, 0, 0, 0, "R3", "R8");
      step(0, 0, 0, 0, 0, 0, 0, 0, "R3", "R8");

      // Directed: I/O phase (R1)
      step(0, 8, 10, 0, 1, 0, 0, 1, "R1", "R6");
      step(0, 16, 10, 0, 1, 0, 0, 1, "R1", "R6");
      // 80-column active RAM waits (R2)
      step(0, 0, 0, 0, 1, 0, 0, 0, "R2", "R6");
      step(0, 632, 255, 7, 1, 0, 0, 0, "R2", "R6");
      // Blanking thresholds (R4)
      step(0, 640, 0, 0, 1, 0, 0, 0, "R4", "R6");
      step(0, 0, 249, 0, 1, 1, 0, 0, "R4", "R6");
      step(0, 0, 250, 0, 1, 1, 0, 0, "R4", "R6");
      step(0, 0, 250, 0, 1, 0, 0, 0, "R4", "R6");
      step(0, 0, 256, 0, 1, 0, 0, 0, "R4", "R6");
      step(0, 0, 10, 8, 1, 0, 0, 0, "R4", "R6");
      // 40-column RAM (R3)
      step(0, 0, 10, 0, 0, 0, 0, 0, "R3", "R6");

      // Long stall with requests during it (R6, R7)
      step(0, 0, 0, 0, 1, 0, 1, 0, "R2", "R6");
      for (int i = 0; i < 85; i++)
         step(0, 8 * (i % 80), 0, 0, 1, 0, 1, 0,
              cat_tag(8 * (i % 80), 0, 0, 1, 0, 0), "R7");
      // Reset in the middle of a stall (R8)
      step(0, 0, 0, 0, 1, 0, 1, 0, "R2", "R6");
      step(0, 0, 0, 0, 1, 0, 0, 0, "R2", "R6");
      step(0, 0, 0, 0, 1, 0, 0, 0, "R2", "R6");
      step(1, 0, 0, 0, 1, 0, 0, 0, "R2", "R8");
      step(0, 8, 0, 0, 0, 0, 0, 1, "R1", "R8");

      // Constrained random (R5 range covered by every delay check)
      for (int i = 0; i < 3000; i++) begin
         int h, v, r;
         bit w, t, rq, io;
         h = 8 * int'($urandom_range(127, 0));
         v = int'($urandom_range(311, 0));
         r = int'($urandom_range(9, 0));
         w = $urandom_range(1, 0) != 0;
         t = $urandom_range(1, 0) != 0;
         rq = $urandom_range(9, 0) < 3;
         io = $urandom_range(3, 0) == 0;
         step(0, h, v, r, w, t, rq, io, cat_tag(h, v, r, w, t, io), "R6");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule